// File: doc/BRIEF.md
# Configurable UART framer with half-duplex driver enable

This block pairs an asynchronous serial transmitter with a receiver. Both share one frame format that can be changed at run time: seven or eight data bits, one or two stop bits, and one of five parity rules. Characters enter and leave on byte-wide valid/ready ports. The serial side is a transmit line, a receive line and a driver-enable output for a half-duplex line driver. Timing comes from a single input pulse that fires sixteen times per bit. The transmitter counts sixteen of these pulses per bit. The receiver uses them to find the middle of each bit.

On the transmit side, the block can also hold the line low for as long as a break request is held. The driver enable stays on for the whole break. Around every character, the enable opens a full bit time before the start bit and closes exactly when the last stop bit ends. No external delay circuit is needed.

On the receive side, each character comes out with a parity-error flag, a framing-error flag and a match flag. The match flag compares the character with a programmable event byte. A line held low past a whole frame is reported once as a break and delivers no character. After a break, the receiver waits for the line to go high again before it looks for the next start bit.

Top module: `uart_frame_core`

## Requirements
- R1: After reset, txd_o is high, txden_o is low, tx_ready_o is high, and rx_valid_o and rx_break_o are low.
- R2: A transmitted character is sent as follows: one low start bit; then the data bits, least significant first, eight when cfg_len8_i=1 or seven (bits 6..0) when cfg_len8_i=0; then the parity bit, if enabled; then one stop bit (cfg_stop2_i=0) or two (cfg_stop2_i=1), each high. Every bit lasts 16 pulses of tick16_i.
- R3: cfg_par_i selects the parity bit. 0 = none (no parity bit). 1 = odd (the data ones plus the parity bit give an odd count). 2 = even. 3 = mark (always 1). 4 = space (always 0).
- R4: txden_o rises on the cycle after a character or break is accepted. It stays high for at least 16 ticks before the start bit falls. It falls on the same clock edge that ends the last stop bit. txd_o is never low while txden_o is low.
- R5: tx_ready_o is low from acceptance until the line has returned to idle, and it is low while brk_req_i is high.
- R6: With brk_req_i held high from idle, txd_o goes low after one lead bit and stays low with txden_o high. After brk_req_i drops, the line goes high at the next bit boundary, and txden_o falls exactly one bit (16 ticks) later.
- R7: A received character is delivered on rx_data_o with rx_valid_o. In 7-bit mode, bit 7 reads 0. The output holds while rx_ready_i is low.
- R8: rx_par_err_o is set with a delivered character when parity is enabled and the received parity bit disagrees with the rule of R3.
- R9: rx_frame_err_o is set with a delivered character when any of its stop bits is sampled low.
- R10: A line kept low from the start bit through the last stop bit and for one more bit raises rx_break_o for exactly one cycle and delivers no character. If the line is high in that extra bit, a zero character with rx_frame_err_o is delivered instead.
- R11: rx_event_o is set with a delivered character when the character equals evt_char_i, comparing only the active data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len8_i | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_stop2_i | input | 1 | 1 = two stop bits, 0 = one |
| cfg_par_i | input | 3 | Parity rule (see R3) |
| evt_char_i | input | 8 | Event byte compared with received characters |
| tick16_i | input | 1 | One-cycle pulse, 16 per bit time |
| brk_req_i | input | 1 | Hold high to transmit a break |
| tx_data_i | input | 8 | Character to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Transmitter accepts a character |
| txd_o | output | 1 | Serial transmit line |
| txden_o | output | 1 | Line driver enable |
| rxd_i | input | 1 | Serial receive line |
| rx_data_o | output | 8 | Received character |
| rx_valid_o | output | 1 | rx_data_o and the flags are valid |
| rx_ready_i | input | 1 | Consumer takes the character |
| rx_frame_err_o | output | 1 | Stop bit sampled low |
| rx_par_err_o | output | 1 | Parity check failed |
| rx_event_o | output | 1 | Character matched the event byte |
| rx_break_o | output | 1 | One-cycle pulse for a detected break |

## Verification
The hardest case to reach is the boundary between a null character with a bad stop bit and a true break. Both are all-low up to the last stop sample and differ only in one further bit. The bench drives the receive line directly to produce each side of that boundary. It also loops the transmitter back onto the receiver during a long transmitted break, so one stimulus checks driver-enable timing around the break and the single break report. A final normal frame confirms that the receiver resumed hunting only after the line returned high.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK, TX_BRKEND
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRKCHK, RX_BRKWAIT
    } rx_state_e;

    // true when the mode carries a parity bit
    function automatic logic par_on(input logic [2:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
               (mode == PAR_MARK) || (mode == PAR_SPACE);
    endfunction

    // parity bit value for a given xor of the data bits
    function automatic logic par_value(input logic [2:0] mode, input logic xr);
        logic p;
        case (mode)
            PAR_ODD:  p = ~xr;
            PAR_EVEN: p = xr;
            PAR_MARK: p = 1'b1;
            default:  p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/uart_frame_sync.sv
module uart_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b1;
                else if (g == 0) chain_q[g] <= d_i;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_frame_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          len8_i,
    input  logic          stop2_i,
    input  logic [2:0]    par_i,
    input  logic          tick_i,
    input  logic          brk_i,
    input  logic [DW-1:0] data_i,
    input  logic          valid_i,
    output logic          ready_o,
    output logic          txd_o,
    output logic          txden_o
);
    localparam int SW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [SW-1:0] LAST_SUB = SW'(OSR-1);

    typedef struct packed {
        tx_state_e     st;
        logic [SW-1:0] sub;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          pb;
        logic          brk;
        logic          stp;
    } tx_reg_t;

    tx_reg_t q, d;

    logic [DW-1:0] mask;
    logic [IW-1:0] last_idx;
    logic          edge_w;

    always_comb begin
        mask     = len8_i ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
        last_idx = len8_i ? IW'(DW-1) : IW'(DW-2);
        edge_w   = tick_i && (q.sub == LAST_SUB);
        d        = q;
        if (tick_i && q.st != TX_IDLE) begin
            d.sub = (q.sub == LAST_SUB) ? '0 : q.sub + 1'b1;
        end
        case (q.st)
            TX_IDLE: begin
                d.sub = '0;
                if (brk_i) begin
                    d.st  = TX_LEAD;
                    d.brk = 1'b1;
                end else if (valid_i) begin
                    d.st  = TX_LEAD;
                    d.brk = 1'b0;
                    d.sh  = data_i & mask;
                    d.pb  = par_value(par_i, ^(data_i & mask));
                end
            end
            TX_LEAD: if (edge_w) d.st = q.brk ? TX_BRK : TX_START;
            TX_START: if (edge_w) begin
                d.st  = TX_DATA;
                d.idx = '0;
            end
            TX_DATA: if (edge_w) begin
                d.sh = q.sh >> 1;
                if (q.idx == last_idx) begin
                    d.st  = par_on(par_i) ? TX_PAR : TX_STOP;
                    d.stp = stop2_i;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            TX_PAR: if (edge_w) begin
                d.st  = TX_STOP;
                d.stp = stop2_i;
            end
            TX_STOP: if (edge_w) begin
                if (q.stp) d.stp = 1'b0;
                else       d.st  = TX_IDLE;
            end
            TX_BRK: if (edge_w && !brk_i) d.st = TX_BRKEND;
            TX_BRKEND: if (edge_w) d.st = TX_IDLE;
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: TX_IDLE, sub: '0, idx: '0, sh: '0, pb: 1'b0, brk: 1'b0, stp: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            TX_START, TX_BRK: txd_o = 1'b0;
            TX_DATA:          txd_o = q.sh[0];
            TX_PAR:           txd_o = q.pb;
            default:          txd_o = 1'b1;
        endcase
    end

    assign txden_o = (q.st != TX_IDLE);
    assign ready_o = (q.st == TX_IDLE) && !brk_i;
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_frame_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          len8_i,
    input  logic          stop2_i,
    input  logic [2:0]    par_i,
    input  logic [DW-1:0] evt_i,
    input  logic          tick_i,
    input  logic          rxd_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    input  logic          ready_i,
    output logic          ferr_o,
    output logic          perr_o,
    output logic          evt_o,
    output logic          brk_o
);
    localparam int SW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [SW-1:0] LAST_SUB = SW'(OSR-1);
    localparam logic [SW-1:0] MID_SUB  = SW'(OSR/2-1);

    typedef struct packed {
        rx_state_e     st;
        logic [SW-1:0] sub;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          pb;
        logic          zero;
        logic          ferr;
        logic          stp;
        logic          ov;
        logic [DW-1:0] od;
        logic          oferr;
        logic          operr;
        logic          oevt;
        logic          obrk;
    } rx_reg_t;

    rx_reg_t q, d;

    logic [DW-1:0] mask;
    logic [IW-1:0] last_idx;
    logic          samp;
    logic          deliver;
    logic          ferr_n;

    always_comb begin
        mask     = len8_i ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
        last_idx = len8_i ? IW'(DW-1) : IW'(DW-2);
        samp     = tick_i && (q.sub == LAST_SUB);
        deliver  = 1'b0;
        ferr_n   = q.ferr;
        d        = q;
        d.obrk   = 1'b0;
        if (q.ov && ready_i) d.ov = 1'b0;
        if (tick_i && q.st != RX_IDLE) begin
            d.sub = (q.sub == LAST_SUB) ? '0 : q.sub + 1'b1;
        end
        case (q.st)
            RX_IDLE: begin
                d.sub = '0;
                if (tick_i && !rxd_i) d.st = RX_START;
            end
            RX_START: if (tick_i && q.sub == MID_SUB) begin
                if (rxd_i) begin
                    d.st = RX_IDLE;
                end else begin
                    d.st   = RX_DATA;
                    d.sub  = '0;
                    d.idx  = '0;
                    d.sh   = '0;
                    d.zero = 1'b1;
                    d.ferr = 1'b0;
                end
            end
            RX_DATA: if (samp) begin
                d.sh[q.idx] = rxd_i;
                if (rxd_i) d.zero = 1'b0;
                if (q.idx == last_idx) begin
                    d.st  = par_on(par_i) ? RX_PAR : RX_STOP;
                    d.stp = stop2_i;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            RX_PAR: if (samp) begin
                d.pb = rxd_i;
                if (rxd_i) d.zero = 1'b0;
                d.st = RX_STOP;
            end
            RX_STOP: if (samp) begin
                ferr_n = q.ferr | ~rxd_i;
                d.ferr = ferr_n;
                if (rxd_i) d.zero = 1'b0;
                if (q.stp) begin
                    d.stp = 1'b0;
                end else if (q.zero && !rxd_i) begin
                    d.st = RX_BRKCHK;
                end else begin
                    d.st    = RX_IDLE;
                    deliver = 1'b1;
                end
            end
            RX_BRKCHK: if (samp) begin
                if (!rxd_i) begin
                    d.obrk = 1'b1;
                    d.st   = RX_BRKWAIT;
                end else begin
                    d.st    = RX_IDLE;
                    deliver = 1'b1;
                end
            end
            RX_BRKWAIT: begin
                d.sub = '0;
                if (rxd_i) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
        // a character finding the output still occupied is dropped
        if (deliver && !d.ov) begin
            d.ov    = 1'b1;
            d.od    = q.sh;
            d.oferr = ferr_n;
            d.operr = par_on(par_i) && (q.pb != par_value(par_i, ^q.sh));
            d.oevt  = (q.sh == (evt_i & mask));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: RX_IDLE, sub: '0, idx: '0, sh: '0, pb: 1'b0, zero: 1'b0,
                   ferr: 1'b0, stp: 1'b0, ov: 1'b0, od: '0, oferr: 1'b0,
                   operr: 1'b0, oevt: 1'b0, obrk: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.od;
    assign valid_o = q.ov;
    assign ferr_o  = q.oferr;
    assign perr_o  = q.operr;
    assign evt_o   = q.oevt;
    assign brk_o   = q.obrk;
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core #(
    parameter int DW  = 8,
    parameter int OSR = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_len8_i,
    input  logic          cfg_stop2_i,
    input  logic [2:0]    cfg_par_i,
    input  logic [DW-1:0] evt_char_i,
    input  logic          tick16_i,
    input  logic          brk_req_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          tx_valid_i,
    output logic          tx_ready_o,
    output logic          txd_o,
    output logic          txden_o,
    input  logic          rxd_i,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_valid_o,
    input  logic          rx_ready_i,
    output logic          rx_frame_err_o,
    output logic          rx_par_err_o,
    output logic          rx_event_o,
    output logic          rx_break_o
);
    logic rxd_s;

    uart_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rxd_i),
        .q_o    (rxd_s)
    );

    uart_frame_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .len8_i  (cfg_len8_i),
        .stop2_i (cfg_stop2_i),
        .par_i   (cfg_par_i),
        .tick_i  (tick16_i),
        .brk_i   (brk_req_i),
        .data_i  (tx_data_i),
        .valid_i (tx_valid_i),
        .ready_o (tx_ready_o),
        .txd_o   (txd_o),
        .txden_o (txden_o)
    );

    uart_frame_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .len8_i  (cfg_len8_i),
        .stop2_i (cfg_stop2_i),
        .par_i   (cfg_par_i),
        .evt_i   (evt_char_i),
        .tick_i  (tick16_i),
        .rxd_i   (rxd_s),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o),
        .ready_i (rx_ready_i),
        .ferr_o  (rx_frame_err_o),
        .perr_o  (rx_par_err_o),
        .evt_o   (rx_event_o),
        .brk_o   (rx_break_o)
    );
endmodule

// File: rtl/uart_frame_chk.sv
module uart_frame_chk #(
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tx_ready_o,
    input logic          txd_o,
    input logic          txden_o,
    input logic [DW-1:0] rx_data_o,
    input logic          rx_valid_o,
    input logic          rx_ready_i,
    input logic          rx_break_o
);
    // R4: the line is only driven low with the driver enabled
    assert_low_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !txd_o |-> txden_o);

    // R4: the enable was already on in the cycle before any falling line edge
    assert_en_leads_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(txd_o) |-> $past(txden_o));

    // R5: ready only when the transmitter is off the line
    assert_ready_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |-> (!txden_o && txd_o));

    // R7: an unaccepted character stays put
    assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

    // R10: a break is reported as a single-cycle pulse
    assert_break_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_break_o |=> !rx_break_o);
endmodule

bind uart_frame_core uart_frame_chk #(.DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_ready_o (tx_ready_o),
    .txd_o      (txd_o),
    .txden_o    (txden_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_ready_i (rx_ready_i),
    .rx_break_o (rx_break_o)
);

// File: tb/uart_frame_core_test.sv
module uart_frame_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len8 = 1'b1, stop2 = 1'b0;
    logic [2:0] par = 3'd0;
    logic [7:0] evt = 8'hA5;
    logic       tick = 1'b0;
    logic       brk = 1'b0;
    logic [7:0] txdat = 8'h00;
    logic       txval = 1'b0;
    logic       txrdy, txd, txden;
    logic       loop = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       rxd;
    logic [7:0] rxdat;
    logic       rxval, ferr, perr, evf, rbrk;

    int tot = 0, bad = 0;
    int got = 0, brks = 0;
    logic [7:0] g_dat;
    logic g_ferr, g_perr, g_evt;

    assign rxd = loop ? txd : rxd_drv;

    always #4 clk = ~clk;

    uart_frame_core uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_len8_i(len8), .cfg_stop2_i(stop2),
        .cfg_par_i(par), .evt_char_i(evt), .tick16_i(tick), .brk_req_i(brk),
        .tx_data_i(txdat), .tx_valid_i(txval), .tx_ready_o(txrdy), .txd_o(txd),
        .txden_o(txden), .rxd_i(rxd), .rx_data_o(rxdat), .rx_valid_o(rxval),
        .rx_ready_i(1'b1), .rx_frame_err_o(ferr), .rx_par_err_o(perr),
        .rx_event_o(evf), .rx_break_o(rbrk)
    );

    initial begin
        forever begin
            @(posedge clk);
            tick <= ~tick;
        end
    end

    always @(posedge clk) begin
        if (rxval) begin
            got    <= got + 1;
            g_dat  <= rxdat;
            g_ferr <= ferr;
            g_perr <= perr;
            g_evt  <= evf;
        end
        if (rbrk) brks <= brks + 1;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] m, input logic [2:0] mode);
        logic xr;
        xr = ^m;
        case (mode)
            3'd1: return ~xr;
            3'd2: return xr;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic tx_frame(input logic [7:0] b);
        logic [15:0] obs, expv;
        logic [7:0]  m;
        int k, n, g0;
        logic rdy_mid, hi, lo;
        m = len8 ? b : {1'b0, b[6:0]};
        expv = '0;
        obs  = '0;
        k = 1;
        for (int i = 0; i < (len8 ? 8 : 7); i++) begin
            expv[k] = m[i];
            k++;
        end
        if (par != 3'd0) begin
            expv[k] = exp_par(m, par);
            k++;
        end
        expv[k] = 1'b1; k++;
        if (stop2) begin expv[k] = 1'b1; k++; end
        @(negedge clk);
        while (!txrdy) @(negedge clk);
        g0 = got;
        txdat = b; txval = 1'b1;
        @(negedge clk);
        txval = 1'b0;
        check(txden == 1'b1, "R4 enable after accept", {31'd0, txden}, 1);
        n = 0;
        while (txd && n < 100) begin @(negedge clk); n++; end
        check(n >= 31 && n <= 32, "R4 lead time", n, 32);
        repeat (16) @(negedge clk);
        obs[0] = txd;
        rdy_mid = txrdy;
        for (int i = 1; i < k; i++) begin
            repeat (32) @(negedge clk);
            obs[i] = txd;
        end
        check(obs == expv, "R2 R3 frame bits", {16'd0, obs}, {16'd0, expv});
        check(!rdy_mid, "R5 busy during frame", {31'd0, rdy_mid}, 0);
        repeat (15) @(negedge clk);
        hi = txden;
        @(negedge clk);
        lo = txden;
        check(hi && !lo, "R4 enable release", {30'd0, hi, lo}, 2);
        check(got == g0 + 1 && g_dat == m && !g_ferr && !g_perr, "R7 loopback rx",
              {g_ferr, g_perr, 22'd0, g_dat}, {24'd0, m});
        check(g_evt == (m == (evt & (len8 ? 8'hFF : 8'h7F))), "R11 event flag",
              {31'd0, g_evt}, {31'd0, (m == (evt & (len8 ? 8'hFF : 8'h7F)))});
    endtask

    task automatic line(input logic v, input int bits);
        rxd_drv = v;
        repeat (32 * bits) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] dv, input logic pe, input logic pb,
                           input logic s1, input logic s2);
        line(1'b0, 1);
        for (int i = 0; i < (len8 ? 8 : 7); i++) line(dv[i], 1);
        if (pe) line(pb, 1);
        line(s1, 1);
        if (stop2) line(s2, 1);
        line(1'b1, 3);
    endtask

    initial begin
        int g0, b0, n;
        logic okb;
        repeat (190000) @(posedge clk);
        tot++; bad++;
        $display("FAIL R1 watchdog act=1 exp=0");
        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    end

    initial begin
        int g0, b0, n;
        logic okb;
        logic [7:0] pat [6];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd && !txden && txrdy && !rxval && !rbrk, "R1 reset state",
              {27'd0, txd, txden, txrdy, rxval, rbrk}, 5'b10100);

        // sweep every frame format through loopback
        for (int c = 0; c < 20; c++) begin
            len8  = c[0];
            stop2 = c[1];
            par   = 3'(c / 4);
            pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5;
            pat[3] = 8'h25; pat[4] = 8'h5A; pat[5] = 8'(c * 37 + 11);
            for (int p = 0; p < 6; p++) tx_frame(pat[p]);
        end

        // direct receive line stimulus
        loop = 1'b0;
        line(1'b1, 2);
        len8 = 1'b1; stop2 = 1'b0; par = 3'd2;
        g0 = got;
        rx_send(8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);
        check(got == g0 + 1 && g_perr && !g_ferr && g_dat == 8'h3C, "R8 even bad parity",
              {g_perr, g_ferr, 22'd0, g_dat}, {2'b10, 22'd0, 8'h3C});
        par = 3'd1; g0 = got;
        rx_send(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1);
        check(got == g0 + 1 && g_perr, "R8 odd bad parity", {31'd0, g_perr}, 1);
        par = 3'd3; g0 = got;
        rx_send(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1);
        check(got == g0 + 1 && g_perr, "R8 mark parity zero", {31'd0, g_perr}, 1);
        par = 3'd4; g0 = got;
        rx_send(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1);
        check(got == g0 + 1 && !g_perr, "R8 space parity good", {31'd0, g_perr}, 0);
        par = 3'd0; g0 = got;
        rx_send(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
        check(got == g0 + 1 && g_ferr && g_dat == 8'h81, "R9 low stop",
              {g_ferr, 23'd0, g_dat}, {1'b1, 23'd0, 8'h81});
        stop2 = 1'b1; g0 = got;
        rx_send(8'h42, 1'b0, 1'b0, 1'b1, 1'b0);
        check(got == g0 + 1 && g_ferr, "R9 second stop low", {31'd0, g_ferr}, 1);
        stop2 = 1'b0; g0 = got; b0 = brks;
        rx_send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        check(got == g0 + 1 && g_ferr && g_dat == 8'h00 && brks == b0, "R10 null char not break",
              {g_ferr, 7'd0, brks - b0, g_dat}, {1'b1, 23'd0, 8'h00});
        len8 = 1'b0; g0 = got;
        rx_send(8'hFF, 1'b0, 1'b0, 1'b1, 1'b1);
        check(got == g0 + 1 && g_dat == 8'h7F, "R7 seven bit mask", {24'd0, g_dat}, 8'h7F);
        len8 = 1'b1; stop2 = 1'b1; par = 3'd2; g0 = got; b0 = brks;
        line(1'b0, 16);
        line(1'b1, 2);
        check(brks == b0 + 1 && got == g0, "R10 line break once",
              {16'(brks - b0), 16'(got - g0)}, 32'h0001_0000);
        rx_send(8'h96, 1'b1, 1'b0, 1'b1, 1'b1);
        check(got == g0 + 1 && g_dat == 8'h96 && !g_perr && !g_ferr, "R10 resume after break",
              {g_perr, g_ferr, 22'd0, g_dat}, {24'd0, 8'h96});

        // transmitted break seen by own receiver
        loop = 1'b1;
        g0 = got; b0 = brks;
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        check(!txrdy && txden, "R5 R6 break accepted", {30'd0, txrdy, txden}, 1);
        n = 0;
        while (txd && n < 100) begin @(negedge clk); n++; end
        check(n >= 31 && n <= 32, "R6 break lead", n, 32);
        okb = 1'b1;
        for (int i = 0; i < 16; i++) begin
            repeat (32) @(negedge clk);
            if (txd || !txden || txrdy) okb = 1'b0;
        end
        check(okb, "R6 break held", {31'd0, okb}, 1);
        brk = 1'b0;
        n = 0;
        while (!txd && n < 100) begin @(negedge clk); n++; end
        check(n <= 32, "R6 break release at boundary", n, 32);
        n = 0;
        while (txden && n < 100) begin @(negedge clk); n++; end
        check(n == 32, "R6 enable tail after break", n, 32);
        check(brks == b0 + 1 && got == g0, "R10 transmitted break seen once",
              {16'(brks - b0), 16'(got - g0)}, 32'h0001_0000);
        tx_frame(8'hC3);

        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    end
endmodule